// File: doc/BRIEF.md
# Instrument Status Summary and Service Request Logic

This block builds the 8-bit status summary that an instrument reports to its controller. Five level inputs feed it: error-queue-not-empty, output-queue-not-empty, and the enabled summaries of the questionable-data, standard-event and operation-status groups. Each input sits in a fixed bit position. A software-written enable mask selects which of these bits may call for service.

The block computes a live master summary. This is the OR of every enabled status bit. Bit 6 of the register itself takes no part in that OR.

A rising edge of the master summary latches a request-for-service flag. The latched flag drives the active-high service-request line. The block offers two read views. The query view shows the live master summary in bit 6 and changes no state. The serial-poll view shows the latched request in bit 6 and clears the latch at the end of the poll cycle. A poll leaves every other bit as it was.

Top module: `stb_srq_top`

## Requirements
- R1: Bits 1 and 0 of both `query_data` and `poll_data` are always 0.
- R2: On both read views, the status bits are mapped as follows: bit 2 follows `err_pending`, bit 3 follows `quest_sum`, bit 4 follows `msg_avail`, bit 5 follows `event_sum` and bit 7 follows `oper_sum`. These bits follow their inputs combinationally, in the same cycle.
- R3: `query_data[6]` is the OR of `query_data & sre_q` over bits 7, 5, 4, 3 and 2, taken combinationally. Bit 6 of the mask and the latched request never contribute. A query read changes no state.
- R4: When `sre_wr_en` is high at a clock edge, `sre_q` takes the value of `sre_wr_data` from the next cycle on, with bit 6 forced to 0. Otherwise `sre_q` holds its value.
- R5: A 0-to-1 change of the master summary, as seen at a clock edge, sets the latched request. `srq` and `poll_data[6]` are then 1 from the following cycle. A master summary that never rises, for example because every input is masked, never raises `srq`.
- R6: While `poll_rd` is high, `poll_data[6]` shows the latched request. After that clock edge the request is 0 and `srq` is low. The request is not set again while the master summary stays high. Only a new rising edge sets it again.
- R7: `poll_data` equals `query_data` in every bit except bit 6, whether or not a poll is in progress.
- R8: If a new rising edge of the master summary falls in the same cycle as a poll, the request stays set. That poll still returns the old request value in bit 6.
- R9: While `rst_n` is low at a clock edge, the mask and the latched request clear. The edge memory of the master summary also clears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_pending | input | 1 | Error queue holds at least one entry |
| quest_sum | input | 1 | Questionable-data group summary |
| msg_avail | input | 1 | Output queue holds at least one message |
| event_sum | input | 1 | Standard-event group summary |
| oper_sum | input | 1 | Operation-status group summary |
| sre_wr_en | input | 1 | Write strobe for the service-request enable mask |
| sre_wr_data | input | 8 | New mask value; bit 6 is discarded |
| sre_q | output | 8 | Current enable mask |
| query_data | output | 8 | Query view, with the live master summary in bit 6 |
| poll_rd | input | 1 | Serial-poll strobe, one cycle per poll |
| poll_data | output | 8 | Poll view, with the latched request in bit 6 |
| srq | output | 1 | Service-request line, active high |

## Verification
The assertions assume that all inputs are synchronous to `clk` and stay stable around the sampling edge. They also assume that `poll_rd` and `sre_wr_en` are held low during reset. The bench drives every input one time unit after a rising edge and keeps both strobes low while `rst_n` is low. It sweeps all 256 mask values against all 32 input patterns. Directed sequences then cover latching, poll clearing, the missing re-latch, a poll that coincides with a new rising edge, and reset.

// File: rtl/stb_pkg.sv
// Shared constants for the status summary block: register width and the
// fixed bit positions that the controller decodes.
package stb_pkg;
    localparam int STB_W     = 8;
    localparam int BIT_ERR   = 2;
    localparam int BIT_QUES  = 3;
    localparam int BIT_MAV   = 4;
    localparam int BIT_ESB   = 5;
    localparam int BIT_MSS   = 6;
    localparam int BIT_OPER  = 7;
    // Bits that may contribute to the master summary.
    localparam logic [STB_W-1:0] SUMMARY_BITS =
        STB_W'((1 << BIT_ERR) | (1 << BIT_QUES) | (1 << BIT_MAV) |
               (1 << BIT_ESB) | (1 << BIT_OPER));
endpackage

// File: rtl/stb_assemble.sv
// Places the five status levels into their bit positions and forms the live
// master summary against the enable mask.
// Assumes: inputs are synchronous levels; bit 6 and bits 1:0 carry no input.
module stb_assemble
    import stb_pkg::*;
#(
    parameter int W = STB_W
) (
    input  logic         err_pending,
    input  logic         quest_sum,
    input  logic         msg_avail,
    input  logic         event_sum,
    input  logic         oper_sum,
    input  logic [W-1:0] enable_mask,
    output logic [W-1:0] status_vec,
    output logic         mss
);
    // Place each level into its fixed position; unused bits stay at 0.
    always_comb begin
        status_vec           = '0;
        status_vec[BIT_ERR]  = err_pending;
        status_vec[BIT_QUES] = quest_sum;
        status_vec[BIT_MAV]  = msg_avail;
        status_vec[BIT_ESB]  = event_sum;
        status_vec[BIT_OPER] = oper_sum;
    end

    // Live OR of the enabled summary bits; bit 6 is outside SUMMARY_BITS.
    always_comb begin
        mss = |(status_vec & enable_mask & SUMMARY_BITS);
    end
endmodule

// File: rtl/stb_mask_reg.sv
// Holds the service-request enable mask written by software.
// Assumes: the write strobe lasts one cycle per write; bit 6 is never stored.
module stb_mask_reg
    import stb_pkg::*;
#(
    parameter int W = STB_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] mask_q
);
    localparam logic [W-1:0] KEEP = ~(W'(1) << BIT_MSS);

    // Load the mask on a write, dropping the master-summary position.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (wr_en)
            mask_q <= wr_data & KEEP;
    end

    // R4
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mask_q == ($past(wr_data) & KEEP));

    // R4
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mask_q));
endmodule

// File: rtl/stb_rqs_latch.sv
// Catches rising edges of the master summary into a request flag that a
// serial poll clears. A new edge in the same cycle as a poll wins.
// Assumes: poll_rd is a one-cycle strobe per poll.
module stb_rqs_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic mss,
    input  logic poll_rd,
    output logic rqs
);
    logic mss_prev;
    logic set_evt;

    // A request arises only where the summary goes from 0 to 1.
    always_comb begin
        set_evt = mss & ~mss_prev;
    end

    // Keep the edge memory and the latched request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mss_prev <= 1'b0;
            rqs      <= 1'b0;
        end else begin
            mss_prev <= mss;
            if (set_evt)
                rqs <= 1'b1;
            else if (poll_rd)
                rqs <= 1'b0;
        end
    end

    // R5
    rise_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> rqs);

    // R6
    poll_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_rd && !set_evt) |=> !rqs);

    // R6
    rqs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!poll_rd && !set_evt) |=> $stable(rqs));
endmodule

// File: rtl/stb_srq_top.sv
// Status summary register with its service-request path. It joins the level
// assembler, the enable mask and the request latch, and it forms the two read
// views that differ only in bit 6.
// Assumes: all inputs are synchronous to clk; strobes are held low in reset.
module stb_srq_top
    import stb_pkg::*;
#(
    parameter int W = STB_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         err_pending,
    input  logic         quest_sum,
    input  logic         msg_avail,
    input  logic         event_sum,
    input  logic         oper_sum,
    input  logic         sre_wr_en,
    input  logic [W-1:0] sre_wr_data,
    output logic [W-1:0] sre_q,
    output logic [W-1:0] query_data,
    input  logic         poll_rd,
    output logic [W-1:0] poll_data,
    output logic         srq
);
    localparam logic [W-1:0] NO_MSS = ~(W'(1) << BIT_MSS);

    logic [W-1:0] status_vec;
    logic         mss;
    logic         rqs;

    stb_mask_reg #(.W(W)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sre_wr_en),
        .wr_data (sre_wr_data),
        .mask_q  (sre_q)
    );

    stb_assemble #(.W(W)) u_asm (
        .err_pending (err_pending),
        .quest_sum   (quest_sum),
        .msg_avail   (msg_avail),
        .event_sum   (event_sum),
        .oper_sum    (oper_sum),
        .enable_mask (sre_q),
        .status_vec  (status_vec),
        .mss         (mss)
    );

    stb_rqs_latch u_rqs (
        .clk     (clk),
        .rst_n   (rst_n),
        .mss     (mss),
        .poll_rd (poll_rd),
        .rqs     (rqs)
    );

    // Query view: live summary in bit 6.
    always_comb begin
        query_data          = status_vec;
        query_data[BIT_MSS] = mss;
    end

    // Poll view: latched request in bit 6.
    always_comb begin
        poll_data          = status_vec;
        poll_data[BIT_MSS] = rqs;
    end

    // Interrupt line follows the latched request.
    always_comb begin
        srq = rqs;
    end

    // R3
    query_mss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        query_data[BIT_MSS] == |(query_data & sre_q & SUMMARY_BITS));

    // R7
    poll_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_data & NO_MSS) == (query_data & NO_MSS));

    // R1
    low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (query_data[1:0] == 2'b00) && (poll_data[1:0] == 2'b00));

    // R6
    srq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_rd && $past(mss) && mss) |=> !srq);
endmodule

// File: tb/stb_srq_top_bench.sv
`timescale 1ns/1ps
module stb_srq_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       err_pending = 0, quest_sum = 0, msg_avail = 0, event_sum = 0, oper_sum = 0;
    logic       sre_wr_en = 0;
    logic [7:0] sre_wr_data = 8'h00;
    logic [7:0] sre_q, query_data, poll_data;
    logic       poll_rd = 0;
    logic       srq;
    int         n_chk = 0;
    int         n_fail = 0;

    always #5 clk = ~clk;

    stb_srq_top u_stb_srq_top (
        .clk(clk), .rst_n(rst_n),
        .err_pending(err_pending), .quest_sum(quest_sum), .msg_avail(msg_avail),
        .event_sum(event_sum), .oper_sum(oper_sum),
        .sre_wr_en(sre_wr_en), .sre_wr_data(sre_wr_data), .sre_q(sre_q),
        .query_data(query_data), .poll_rd(poll_rd), .poll_data(poll_data), .srq(srq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Packing: v[0]=err, v[1]=quest, v[2]=mav, v[3]=event, v[4]=oper.
    task automatic set_in(input logic [4:0] v);
        {oper_sum, event_sum, msg_avail, quest_sum, err_pending} = v;
    endtask

    function automatic logic [7:0] exp_status(input logic [4:0] v);
        return {v[4], 1'b0, v[3], v[2], v[1], v[0], 2'b00};
    endfunction

    task automatic write_mask(input logic [7:0] m);
        sre_wr_en = 1'b1;
        sre_wr_data = m;
        tick();
        sre_wr_en = 1'b0;
        chk("R4 mask readback", sre_q, m & 8'hBF);
    endtask

    task automatic poll_once();
        poll_rd = 1'b1;
        tick();
        poll_rd = 1'b0;
        #1;
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] st;
        logic       m;
        // Reset state (R9)
        repeat (3) tick();
        chk("R9 reset srq", {7'b0, srq}, 8'h00);
        chk("R9 reset mask", sre_q, 8'h00);
        chk("R9 reset query", query_data, 8'h00);
        rst_n = 1'b1;
        tick();

        // All inputs high, nothing enabled: no request (R5)
        set_in(5'h1F);
        repeat (3) tick();
        chk("R5 masked no srq", {7'b0, srq}, 8'h00);
        chk("R2 all levels", query_data, 8'hBC);

        // Full sweep of masks and inputs (R1 R2 R3 R4 R7)
        for (int mk = 0; mk < 256; mk++) begin
            write_mask(8'(mk));
            for (int v = 0; v < 32; v++) begin
                set_in(5'(v));
                #1;
                st = exp_status(5'(v));
                m  = |(st & 8'(mk) & 8'hBF);
                chk("R3 query view", query_data, st | {1'b0, m, 6'b0});
                chk("R7 poll other bits", poll_data & 8'hBF, st);
                chk("R1 low bits", {6'b0, poll_data[1:0] | query_data[1:0]}, 8'h00);
                tick();
            end
        end

        // Quiet start for directed sequences
        set_in(5'h00);
        write_mask(8'h00);
        poll_once();
        chk("R6 cleared before directed", {7'b0, srq}, 8'h00);

        // Rising edge latches (R5)
        write_mask(8'h10);
        set_in(5'b00100);
        #1;
        chk("R5 srq not before edge", {7'b0, srq}, 8'h00);
        chk("R3 live mss", query_data, 8'h50);
        tick();
        chk("R5 srq after edge", {7'b0, srq}, 8'h01);
        chk("R5 poll bit6 set", poll_data, 8'h50);

        // Poll returns and clears, no re-latch (R6)
        poll_rd = 1'b1;
        #1;
        chk("R6 poll returns request", poll_data, 8'h50);
        tick();
        poll_rd = 1'b0;
        #1;
        chk("R6 srq cleared", {7'b0, srq}, 8'h00);
        chk("R6 poll bit6 cleared", poll_data, 8'h10);
        chk("R7 query unaffected", query_data, 8'h50);
        repeat (4) tick();
        chk("R6 no re-latch", {7'b0, srq}, 8'h00);

        // New rising edge sets again (R5)
        set_in(5'h00);
        tick();
        set_in(5'b00100);
        tick();
        chk("R5 second edge", {7'b0, srq}, 8'h01);

        // Bit 6 excluded, query clears nothing (R3)
        write_mask(8'hFF);
        set_in(5'h00);
        #1;
        chk("R3 bit6 not self-feeding", query_data, 8'h00);
        tick();
        chk("R3 query leaves request", {7'b0, srq}, 8'h01);

        // Edge and poll in the same cycle (R8)
        set_in(5'b00001);
        poll_rd = 1'b1;
        #1;
        chk("R8 poll sees old request", poll_data, 8'h44);
        tick();
        poll_rd = 1'b0;
        #1;
        chk("R8 set wins", {7'b0, srq}, 8'h01);

        // Reset clears mask and latch (R9)
        rst_n = 1'b0;
        tick();
        chk("R9 srq cleared", {7'b0, srq}, 8'h00);
        chk("R9 mask cleared", sre_q, 8'h00);
        rst_n = 1'b1;
        repeat (2) tick();
        chk("R9 stays clear", {7'b0, srq}, 8'h00);

        // Poll with no request (R6)
        poll_rd = 1'b1;
        #1;
        chk("R6 idle poll", poll_data, 8'h04);
        tick();
        poll_rd = 1'b0;
        #1;
        chk("R7 idle poll keeps bits", poll_data, 8'h04);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule